// File: doc/BRIEF.md
# Fixed-Point Arithmetic Unit with Output Resizing

This combinational unit takes two fixed-point operands, each with its own count of integer bits and fraction bits, and adds, subtracts or multiplies them. The operation, the signedness of the operands and all formats are set by parameters. The unit first forms the exact result in a full-precision format that is wide enough for every operand value. It then converts that result to a parameterised output format, dropping or appending fraction bits and shrinking or growing the integer part.

A word with `IW` integer bits and `QW` fraction bits is `IW+QW` bits wide, and its raw value is scaled by `2^-QW`. For signed operands the sign bit is counted in `IW`. When the output integer part is narrower than the full-precision one, a policy parameter selects modulo wrap-around or saturation. In the flagged variant an active-high output reports that the value did not fit. This variant saturates by default. The unflagged variant wraps by default and holds its flag output low. A designer instantiates one unit per arithmetic node of a datapath and chooses its formats to match.

Top module: `fxp_arith`

## Requirements
- R1: For add, the full-precision result has max(IW_A, IW_B)+1 integer bits and max(QW_A, QW_B) fraction bits. The operand with fewer fraction bits is aligned by appending zero LSBs, and the sum is exact when the output format can hold it.
- R2: For subtract, the full-precision format follows the same sizing rule as add and holds a−b exactly. Subtracting two unsigned operands gives a signed (two's complement) result and a signed output format.
- R3: For multiply, the full-precision result has IW_A+IW_B integer bits and QW_A+QW_B fraction bits, and it holds the exact product.
- R4: When the output has fewer fraction bits than the full result, the excess LSBs are dropped, which rounds toward negative infinity. When it has more, zero LSBs are appended.
- R5: With SIGNED_OPS=1 the operands are two's complement words and are sign-extended. With SIGNED_OPS=0 they are unsigned and zero-extended.
- R6: With SATURATE=0, a value outside the output range is wrapped: the output holds the low IW_O+QW_O bits of the truncated result.
- R7: With SATURATE=1, a value outside the output range is clamped. A signed output goes to 0 followed by all ones (most positive) or 1 followed by all zeros (most negative). An unsigned output goes to all ones.
- R8: `clip_flag` is high exactly when WITH_FLAG=1 and the truncated result lies outside the output range. It stays low when WITH_FLAG=0. SATURATE defaults to the value of WITH_FLAG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | IW_A+QW_A | First operand, raw fixed-point word |
| b | input | IW_B+QW_B | Second operand, raw fixed-point word |
| y | output | IW_O+QW_O | Resized result, raw fixed-point word |
| clip_flag | output | 1 | High when the result did not fit the output range (flagged variant only) |

## Verification
On every evaluation, the embedded assertions check several properties. Operand extension must round-trip to the original word. The full-precision sum or difference must invert back to an operand, and a zero factor must give a zero product. A result that fits must reappear unchanged at the output, and a saturated output must lie on the same side as the true value. Only the bench scenarios can show that the numeric value is right across formats. These cover truncation toward negative infinity on negative values, the exact wrap pattern and clamp limits at the format corners, the signed result of unsigned subtraction, and the flag policy of each variant. The bench checks four differently parameterised instances against an integer reference model.

// File: rtl/fxp_pkg.sv
// Package: fxp_pkg
// Shared operation codes and format-sizing helpers for the fixed-point unit.
// Assumes formats are small enough that all widths fit in a 32-bit int.
package fxp_pkg;

    typedef enum logic [1:0] {
        FXP_ADD = 2'd0,
        FXP_SUB = 2'd1,
        FXP_MUL = 2'd2
    } fxp_op_e;

    // Larger of two integers.
    function automatic int fxp_max(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Integer bits of the full-precision result for a given operation.
    function automatic int fxp_full_iw(input fxp_op_e op, input int iw_a, input int iw_b);
        return (op == FXP_MUL) ? (iw_a + iw_b) : (fxp_max(iw_a, iw_b) + 1);
    endfunction

    // Fraction bits of the full-precision result for a given operation.
    function automatic int fxp_full_qw(input fxp_op_e op, input int qw_a, input int qw_b);
        return (op == FXP_MUL) ? (qw_a + qw_b) : fxp_max(qw_a, qw_b);
    endfunction

endpackage

// File: rtl/fxp_extend.sv
// Module: fxp_extend
// Places an operand word into a wider word, shifted left by SHIFT positions
// (zero LSBs appended) and extended at the top by sign or zero.
// Assumes W_OUT >= W_IN + SHIFT.
module fxp_extend #(
    parameter int W_IN   = 4,
    parameter int W_OUT  = 8,
    parameter int SHIFT  = 0,
    parameter bit SIGNED = 1'b1
) (
    input  logic [W_IN-1:0]  din,
    output logic [W_OUT-1:0] dout
);

    localparam int TOP_IN = W_IN - 1;

    // Select each output bit from the shifted operand, zero fill, or sign fill.
    always_comb begin
        for (int j = 0; j < W_OUT; j++) begin
            if (j < SHIFT)
                dout[j] = 1'b0;
            else if (j - SHIFT < W_IN)
                dout[j] = din[j - SHIFT];
            else
                dout[j] = SIGNED ? din[TOP_IN] : 1'b0;
        end
    end

    // Shifting back must recover the operand word unchanged.
    logic [W_OUT-1:0] back;
    always_comb begin
        back = dout >> SHIFT;
        p_extend_roundtrip_r5: assert (back[W_IN-1:0] == din)
            else $error("extend lost operand bits");
    end

    // The top bit must carry the operand sign (signed) or zero (unsigned).
    always_comb begin
        p_extend_sign_r5: assert (dout[W_OUT-1] == (SIGNED ? din[TOP_IN] : 1'b0))
            else $error("extend top bit wrong");
    end

endmodule

// File: rtl/fxp_full_op.sv
// Module: fxp_full_op
// Performs the selected operation on two operands already extended to the
// full-precision width. Results are taken modulo 2^W, which is exact because
// the full-precision width is sized to hold every result.
module fxp_full_op #(
    parameter fxp_pkg::fxp_op_e OP = fxp_pkg::FXP_ADD,
    parameter int W = 8
) (
    input  logic [W-1:0] xa,
    input  logic [W-1:0] xb,
    output logic [W-1:0] res
);

    generate
        if (OP == fxp_pkg::FXP_MUL) begin : g_mul
            // Low W bits of the product; equal for signed and unsigned words.
            always_comb res = xa * xb;

            // A zero factor must give a zero product.
            always_comb begin
                if (xa == '0 || xb == '0)
                    p_mul_zero_r3: assert (res == '0) else $error("nonzero product of zero");
            end
        end else if (OP == fxp_pkg::FXP_SUB) begin : g_sub
            // Difference at full precision.
            always_comb res = xa - xb;

            // Adding the subtrahend back must restore the minuend.
            always_comb begin
                p_sub_inverse_r2: assert ((res + xb) == xa) else $error("difference not invertible");
            end
        end else begin : g_add
            // Sum at full precision.
            always_comb res = xa + xb;

            // Removing one addend must restore the other.
            always_comb begin
                p_add_inverse_r1: assert ((res - xb) == xa) else $error("sum not invertible");
            end
        end
    endgenerate

endmodule

// File: rtl/fxp_resize.sv
// Module: fxp_resize
// Converts a full-precision word (I_F.Q_F) into the output format (IW_O.Q_O).
// Fraction bits are truncated (floor) or zero-padded; an out-of-range integer
// part is wrapped or saturated, and optionally flagged.
// Assumes W_F > Q_F and IW_O >= 1.
module fxp_resize #(
    parameter int W_F       = 10,
    parameter int Q_F       = 5,
    parameter int IW_O      = 4,
    parameter int Q_O       = 2,
    parameter bit SIGNED    = 1'b1,
    parameter bit SATURATE  = 1'b1,
    parameter bit WITH_FLAG = 1'b1
) (
    input  logic [W_F-1:0]       full,
    output logic [IW_O+Q_O-1:0]  y,
    output logic                 flag
);

    localparam int I_F  = W_F - Q_F;
    localparam int I_M  = (I_F > IW_O) ? I_F : IW_O;
    localparam int W_M  = I_M + Q_O;
    localparam int W_O  = IW_O + Q_O;
    localparam int TOPF = W_F - 1;

    logic [W_M-1:0] mid;
    logic           ovf;
    logic           neg;
    logic [W_O-1:0] sat_val;

    // Rescale to Q_O fraction bits at a width that holds every integer value.
    always_comb begin
        for (int j = 0; j < W_M; j++) begin
            if (j + Q_F - Q_O < 0)
                mid[j] = 1'b0;
            else if (j + Q_F - Q_O >= W_F)
                mid[j] = SIGNED ? full[TOPF] : 1'b0;
            else
                mid[j] = full[j + Q_F - Q_O];
        end
    end

    // Detect bits above the output range that are not redundant.
    always_comb begin
        ovf = 1'b0;
        for (int j = 0; j < W_M; j++) begin
            if (SIGNED && j >= W_O - 1 && mid[j] != mid[W_M-1])
                ovf = 1'b1;
            if (!SIGNED && j >= W_O && mid[j])
                ovf = 1'b1;
        end
    end

    // Build the clamp value for the side the true value lies on.
    always_comb begin
        neg = SIGNED & mid[W_M-1];
        for (int j = 0; j < W_O; j++) begin
            if (!SIGNED)
                sat_val[j] = 1'b1;
            else if (j == W_O - 1)
                sat_val[j] = neg;
            else
                sat_val[j] = ~neg;
        end
    end

    // Choose clamp or wrapped low bits, and report the range violation.
    always_comb begin
        y    = (SATURATE && ovf) ? sat_val : mid[W_O-1:0];
        flag = WITH_FLAG && ovf;
    end

    // A value that fits must come out unchanged once extended back.
    always_comb begin
        if (!ovf) begin
            for (int j = 0; j < W_M; j++) begin
                p_fit_exact_r4: assert (mid[j] == ((j < W_O) ? y[j] : (SIGNED ? y[W_O-1] : 1'b0)))
                    else $error("in-range value altered by resize");
            end
        end
    end

    // A saturated signed output must keep the sign of the true value.
    always_comb begin
        if (SATURATE && ovf && SIGNED)
            p_sat_side_r7: assert (y[W_O-1] == mid[W_M-1]) else $error("clamp on wrong side");
    end

    // A saturated unsigned output must be the largest code.
    always_comb begin
        if (SATURATE && ovf && !SIGNED)
            p_sat_unsigned_r7: assert (&y) else $error("unsigned clamp not all ones");
    end

endmodule

// File: rtl/fxp_arith.sv
// Module: fxp_arith
// Fixed-point add / subtract / multiply with resizing to a parameterised
// output format. Purely combinational. Operands are raw words of
// IW+QW bits; signedness of both operands is chosen by SIGNED_OPS.
// Unsigned subtraction produces a signed result and signed output format.
module fxp_arith #(
    parameter fxp_pkg::fxp_op_e OP = fxp_pkg::FXP_ADD,
    parameter bit SIGNED_OPS = 1'b1,
    parameter int IW_A       = 4,
    parameter int QW_A       = 3,
    parameter int IW_B       = 3,
    parameter int QW_B       = 5,
    parameter int IW_O       = 4,
    parameter int QW_O       = 2,
    parameter bit WITH_FLAG  = 1'b1,
    parameter bit SATURATE   = WITH_FLAG
) (
    input  logic [IW_A+QW_A-1:0] a,
    input  logic [IW_B+QW_B-1:0] b,
    output logic [IW_O+QW_O-1:0] y,
    output logic                 clip_flag
);

    localparam bit IS_MUL     = (OP == fxp_pkg::FXP_MUL);
    localparam bit RES_SIGNED = SIGNED_OPS || (OP == fxp_pkg::FXP_SUB);
    localparam int IW_F       = fxp_pkg::fxp_full_iw(OP, IW_A, IW_B);
    localparam int QW_F       = fxp_pkg::fxp_full_qw(OP, QW_A, QW_B);
    localparam int W_F        = IW_F + QW_F;
    localparam int SH_A       = IS_MUL ? 0 : (QW_F - QW_A);
    localparam int SH_B       = IS_MUL ? 0 : (QW_F - QW_B);

    logic [W_F-1:0] ext_a;
    logic [W_F-1:0] ext_b;
    logic [W_F-1:0] full;

    fxp_extend #(
        .W_IN  (IW_A + QW_A),
        .W_OUT (W_F),
        .SHIFT (SH_A),
        .SIGNED(SIGNED_OPS)
    ) u_ext_a (
        .din (a),
        .dout(ext_a)
    );

    fxp_extend #(
        .W_IN  (IW_B + QW_B),
        .W_OUT (W_F),
        .SHIFT (SH_B),
        .SIGNED(SIGNED_OPS)
    ) u_ext_b (
        .din (b),
        .dout(ext_b)
    );

    fxp_full_op #(
        .OP(OP),
        .W (W_F)
    ) u_op (
        .xa (ext_a),
        .xb (ext_b),
        .res(full)
    );

    fxp_resize #(
        .W_F      (W_F),
        .Q_F      (QW_F),
        .IW_O     (IW_O),
        .Q_O      (QW_O),
        .SIGNED   (RES_SIGNED),
        .SATURATE (SATURATE),
        .WITH_FLAG(WITH_FLAG)
    ) u_resize (
        .full(full),
        .y   (y),
        .flag(clip_flag)
    );

    // The unflagged variant must never raise the flag.
    always_comb begin
        if (!WITH_FLAG)
            p_flag_quiet_r8: assert (!clip_flag) else $error("flag raised without flag variant");
    end

endmodule

// File: tb/fxp_arith_bench.sv
`timescale 1ns/1ps
module fxp_arith_bench;

    // Instance formats: 1 signed add saturate+flag, 2 unsigned sub wrap no flag,
    // 3 signed mul saturate+flag, 4 unsigned add saturate+flag (fraction widened).
    localparam int A1I = 4, A1Q = 3, B1I = 3, B1Q = 5, O1I = 4, O1Q = 2;
    localparam int A2I = 4, A2Q = 2, B2I = 4, B2Q = 2, O2I = 3, O2Q = 3;
    localparam int A3I = 3, A3Q = 4, B3I = 3, B3Q = 4, O3I = 4, O3Q = 3;
    localparam int A4I = 4, A4Q = 1, B4I = 2, B4Q = 3, O4I = 3, O4Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [A1I+A1Q-1:0] a1; logic [B1I+B1Q-1:0] b1; logic [O1I+O1Q-1:0] y1; logic f1;
    logic [A2I+A2Q-1:0] a2; logic [B2I+B2Q-1:0] b2; logic [O2I+O2Q-1:0] y2; logic f2;
    logic [A3I+A3Q-1:0] a3; logic [B3I+B3Q-1:0] b3; logic [O3I+O3Q-1:0] y3; logic f3;
    logic [A4I+A4Q-1:0] a4; logic [B4I+B4Q-1:0] b4; logic [O4I+O4Q-1:0] y4; logic f4;

    fxp_arith #(.OP(fxp_pkg::FXP_ADD), .SIGNED_OPS(1'b1), .IW_A(A1I), .QW_A(A1Q),
                .IW_B(B1I), .QW_B(B1Q), .IW_O(O1I), .QW_O(O1Q), .WITH_FLAG(1'b1))
        u_fxp_arith (.a(a1), .b(b1), .y(y1), .clip_flag(f1));

    fxp_arith #(.OP(fxp_pkg::FXP_SUB), .SIGNED_OPS(1'b0), .IW_A(A2I), .QW_A(A2Q),
                .IW_B(B2I), .QW_B(B2Q), .IW_O(O2I), .QW_O(O2Q), .WITH_FLAG(1'b0))
        u_fxp_arith_sub (.a(a2), .b(b2), .y(y2), .clip_flag(f2));

    fxp_arith #(.OP(fxp_pkg::FXP_MUL), .SIGNED_OPS(1'b1), .IW_A(A3I), .QW_A(A3Q),
                .IW_B(B3I), .QW_B(B3Q), .IW_O(O3I), .QW_O(O3Q), .WITH_FLAG(1'b1))
        u_fxp_arith_mul (.a(a3), .b(b3), .y(y3), .clip_flag(f3));

    fxp_arith #(.OP(fxp_pkg::FXP_ADD), .SIGNED_OPS(1'b0), .IW_A(A4I), .QW_A(A4Q),
                .IW_B(B4I), .QW_B(B4Q), .IW_O(O4I), .QW_O(O4Q), .WITH_FLAG(1'b1))
        u_fxp_arith_uadd (.a(a4), .b(b4), .y(y4), .clip_flag(f4));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Compare one value and report a failure with the requirement tag.
    task automatic check(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Interpret a raw word of width w as signed or unsigned.
    function automatic longint interp(input longint raw, input int w, input bit sg);
        longint m;
        m = (64'sd1 <<< w) - 1;
        raw = raw & m;
        if (sg && raw[w-1]) return raw - (64'sd1 <<< w);
        return raw;
    endfunction

    // Reference model: exact arithmetic, floor rescale, then wrap or clamp.
    task automatic model(input int op, input bit sg, input int ia, input int qa,
                         input int ib, input int qb, input int io, input int qo,
                         input bit sat, input bit fl, input longint ra, input longint rb,
                         output longint ey, output bit ef, output bit eovf);
        longint va, vb, v, lo, hi;
        int qf, wo;
        bit rsg;
        va = interp(ra, ia + qa, sg);
        vb = interp(rb, ib + qb, sg);
        if (op == 2) begin
            v  = va * vb;
            qf = qa + qb;
        end else begin
            qf = (qa > qb) ? qa : qb;
            va = va <<< (qf - qa);
            vb = vb <<< (qf - qb);
            v  = (op == 0) ? va + vb : va - vb;
        end
        if (qo >= qf) v = v <<< (qo - qf);
        else          v = v >>> (qf - qo);
        rsg = sg || (op == 1);
        wo  = io + qo;
        lo  = rsg ? -(64'sd1 <<< (wo - 1)) : 64'sd0;
        hi  = rsg ? (64'sd1 <<< (wo - 1)) - 1 : (64'sd1 <<< wo) - 1;
        eovf = (v < lo) || (v > hi);
        if (eovf && sat) v = (v < lo) ? lo : hi;
        ey = v & ((64'sd1 <<< wo) - 1);
        ef = fl && eovf;
    endtask

    // Requirement tag for a value check, from the instance and outcome.
    function automatic string tag_for(input int inst, input bit ovf, input bit sat, input bit negin);
        if (ovf) return sat ? "R7" : "R6";
        case (inst)
            1: return negin ? "R5" : "R4";
            2: return "R2";
            3: return "R3";
            default: return "R1";
        endcase
    endfunction

    // Check all four instances against the model for the current inputs.
    task automatic check_all();
        longint ey; bit ef, eo;
        model(0, 1'b1, A1I, A1Q, B1I, B1Q, O1I, O1Q, 1'b1, 1'b1, longint'(a1), longint'(b1), ey, ef, eo);
        check(tag_for(1, eo, 1'b1, a1[A1I+A1Q-1] | b1[B1I+B1Q-1]), "signed add y", longint'(y1), ey);
        check("R8", "signed add flag", longint'(f1), longint'(ef));
        model(1, 1'b0, A2I, A2Q, B2I, B2Q, O2I, O2Q, 1'b0, 1'b0, longint'(a2), longint'(b2), ey, ef, eo);
        check(tag_for(2, eo, 1'b0, 1'b0), "unsigned sub y", longint'(y2), ey);
        check("R8", "unsigned sub flag", longint'(f2), longint'(ef));
        model(2, 1'b1, A3I, A3Q, B3I, B3Q, O3I, O3Q, 1'b1, 1'b1, longint'(a3), longint'(b3), ey, ef, eo);
        check(tag_for(3, eo, 1'b1, 1'b0), "signed mul y", longint'(y3), ey);
        check("R8", "signed mul flag", longint'(f3), longint'(ef));
        model(0, 1'b0, A4I, A4Q, B4I, B4Q, O4I, O4Q, 1'b1, 1'b1, longint'(a4), longint'(b4), ey, ef, eo);
        check(tag_for(4, eo, 1'b1, 1'b0), "unsigned add y", longint'(y4), ey);
        check("R8", "unsigned add flag", longint'(f4), longint'(ef));
    endtask

    // Corner patterns: 0 zero, 1 all ones, 2 msb only, 3 all but msb, 4 lsb only.
    function automatic longint pat(input int kind, input int w);
        case (kind)
            0: return 0;
            1: return (64'sd1 <<< w) - 1;
            2: return 64'sd1 <<< (w - 1);
            3: return (64'sd1 <<< (w - 1)) - 1;
            default: return 1;
        endcase
    endfunction

    // Drive inputs away from the clock edge and check after settling.
    task automatic apply(input longint pa, input longint pb, input bit use_pat, input int ka, input int kb);
        @(negedge clk);
        if (use_pat) begin
            a1 = pat(ka, A1I + A1Q); b1 = pat(kb, B1I + B1Q);
            a2 = pat(ka, A2I + A2Q); b2 = pat(kb, B2I + B2Q);
            a3 = pat(ka, A3I + A3Q); b3 = pat(kb, B3I + B3Q);
            a4 = pat(ka, A4I + A4Q); b4 = pat(kb, B4I + B4Q);
        end else begin
            a1 = pa[A1I+A1Q-1:0]; b1 = pb[B1I+B1Q-1:0];
            a2 = pa[A2I+A2Q-1:0]; b2 = pb[B2I+B2Q-1:0];
            a3 = pa[A3I+A3Q-1:0]; b3 = pb[B3I+B3Q-1:0];
            a4 = pa[A4I+A4Q-1:0]; b4 = pb[B4I+B4Q-1:0];
        end
        #3;
        check_all();
    endtask

    // Print the one summary line and end the run.
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        longint ra, rb;
        seed = 32'd12345;
        a1 = '0; b1 = '0; a2 = '0; b2 = '0; a3 = '0; b3 = '0; a4 = '0; b4 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // Reset-time state: zero operands give zero results and no flags (R1, R8).
        check("R1", "idle y1", longint'(y1), 0);
        check("R8", "idle flag", longint'(f1 | f2 | f3 | f4), 0);

        // R4: -0.125 + 0 floors to -0.25 (raw all ones in 6 bits).
        @(negedge clk);
        a1 = 7'h7F; b1 = 8'h00;
        #3;
        check("R4", "floor of negative", longint'(y1), 63);
        // R4: +0.125 truncates to 0.
        a1 = 7'h01;
        #3;
        check("R4", "truncate positive", longint'(y1), 0);
        // R2: unsigned 0 - 0.25 = -0.25, signed 6-bit raw -2 -> 62.
        a2 = 6'h00; b2 = 6'h01;
        #3;
        check("R2", "unsigned sub negative", longint'(y2), 62);

        // Directed corner grid across all instances.
        for (int ka = 0; ka < 5; ka++)
            for (int kb = 0; kb < 5; kb++)
                apply(0, 0, 1'b1, ka, kb);

        // Seeded random vectors.
        void'($urandom(seed));
        for (int n = 0; n < 500; n++) begin
            ra = longint'($urandom());
            rb = longint'($urandom());
            apply(ra, rb, 1'b0, 0, 0);
        end
        finish_run();
    end

endmodule